// File: doc/BRIEF.md
# Fused-Loop Matrix Multiplier

This block computes the product of two 16x16 matrices of 32-bit integers. Both operand matrices sit in external single-port memories, and the block writes the 16x16 result into a third external memory. The block reads through an address and a chip-enable output, and the read data comes back one cycle later. It writes through address, chip-enable, write-enable and data outputs. Element (r,c) of every matrix sits at address r*16+c.

The row, column and inner-index loops run as one flattened iteration space of 4096 steps. The block issues one step per clock, so both operand memories are read on every cycle of a run. A short pipeline multiplies the returned pair of operands and adds the product to the running dot product. On the last inner step of each (row, column) pair the finished sum goes to the result memory. A start/done/idle/ready handshake frames each run.

Top module: `mm_engine`

## Requirements
- R1: After reset, idle is 1 and done, ready, a_ce, b_ce, c_ce and c_we are all 0. While idle is 1, no read or write is issued.
- R2: Every result element C[r*16+c] equals the sum over k of A[r*16+k]*B[k*16+c]. The matrices hold signed 32-bit integers, and each element is stored at address row*16+column.
- R3: A run makes exactly 256 writes, with c_ce and c_we both 1. Result addresses go in ascending order 0..255, with the row outer and the column inner.
- R4: Start is sampled 1 while idle in cycle S. Iteration n = r*256+c*16+k is then issued in cycle S+1+n with a_ce=b_ce=1, a_addr=r*16+k and b_addr=k*16+c. The reads run on 4096 consecutive cycles, one per clock.
- R5: Done is a one-cycle pulse in cycle S+4099, one cycle after the final write in cycle S+4098. The write for pair p=r*16+c is presented in cycle S+18+16p.
- R6: Start is ignored while a run is in progress. A start pulse in the middle of a run changes no read, no write and no timing.
- R7: Ready is a one-cycle pulse in cycle S+4096, the cycle that issues the last iteration. Idle is 0 from cycle S+1 through S+4099 and is 1 again from S+4100.
- R8: Sums wrap modulo 2^32. Only the low 32 bits of each product and of each sum are kept.
- R9: The accumulator restarts at zero for every (row, column) pair, including the first pair of a run that directly follows another run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| done | output | 1 | One-cycle pulse after the final write |
| idle | output | 1 | No run in progress |
| ready | output | 1 | Pulse when the last iteration is issued |
| a_addr | output | 8 | Operand A read address |
| a_ce | output | 1 | Operand A read enable |
| a_q | input | 32 | Operand A read data, one cycle after a_ce |
| b_addr | output | 8 | Operand B read address |
| b_ce | output | 1 | Operand B read enable |
| b_q | input | 32 | Operand B read data, one cycle after b_ce |
| c_addr | output | 8 | Result write address |
| c_ce | output | 1 | Result memory enable |
| c_we | output | 1 | Result write enable |
| c_d | output | 32 | Result write data |

## Verification
The hardest case to reach from the ports is a pair whose sum depends on the accumulator having been cleared. Two runs go back to back with different operands, so a stale sum left from the previous pair or the previous run would corrupt the first element. Wrap-around of products and sums is forced with directed operands whose exact products are multiples of 2^32 or negative. The stimulus also pulses start in the middle of a run and checks that every read, every write and the done cycle match an unperturbed run.

// File: rtl/mm_engine.sv
module mm_engine #(
  parameter int N  = 16,
  parameter int DW = 32,
  parameter int LG = $clog2(N),
  parameter int AW = 2 * LG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  output logic          idle,
  output logic          ready,
  output logic [AW-1:0] a_addr,
  output logic          a_ce,
  input  logic [DW-1:0] a_q,
  output logic [AW-1:0] b_addr,
  output logic          b_ce,
  input  logic [DW-1:0] b_q,
  output logic [AW-1:0] c_addr,
  output logic          c_ce,
  output logic          c_we,
  output logic [DW-1:0] c_d
);
  localparam logic [LG-1:0] TOP = LG'(N - 1);

  logic          run;
  logic [LG-1:0] ri, cj, kk;
  logic          v1, first1, last1, fin1, fin2;
  logic [AW-1:0] caddr1;
  logic [DW-1:0] acc, prod, sum;

  wire last_it = run && ri == TOP && cj == TOP && kk == TOP;

  assign a_addr = {ri, kk};
  assign b_addr = {kk, cj};
  assign a_ce   = run;
  assign b_ce   = run;
  assign ready  = last_it;
  assign idle   = !(run || v1 || c_we || done);
  assign prod   = a_q * b_q;
  assign sum    = (first1 ? '0 : acc) + prod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      ri  <= '0;
      cj  <= '0;
      kk  <= '0;
    end else if (!run) begin
      if (start && idle) begin
        run <= 1'b1;
        ri  <= '0;
        cj  <= '0;
        kk  <= '0;
      end
    end else begin
      kk <= kk + 1'b1;
      if (kk == TOP) begin
        cj <= cj + 1'b1;
        if (cj == TOP) ri <= ri + 1'b1;
      end
      if (last_it) run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      first1 <= 1'b0;
      last1  <= 1'b0;
      fin1   <= 1'b0;
      fin2   <= 1'b0;
      caddr1 <= '0;
      acc    <= '0;
      c_ce   <= 1'b0;
      c_we   <= 1'b0;
      c_addr <= '0;
      c_d    <= '0;
      done   <= 1'b0;
    end else begin
      v1     <= run;
      first1 <= kk == '0;
      last1  <= kk == TOP;
      fin1   <= last_it;
      fin2   <= fin1;
      done   <= fin2;
      caddr1 <= {ri, cj};
      if (v1) acc <= sum;
      c_ce <= v1 && last1;
      c_we <= v1 && last1;
      if (v1 && last1) begin
        c_addr <= caddr1;
        c_d    <= sum;
      end
    end
  end
endmodule

module mm_engine_chk #(
  parameter int N  = 16,
  parameter int DW = 32,
  parameter int LG = $clog2(N),
  parameter int AW = 2 * LG
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          idle,
  input logic          ready,
  input logic [AW-1:0] a_addr,
  input logic          a_ce,
  input logic [DW-1:0] a_q,
  input logic [AW-1:0] b_addr,
  input logic          b_ce,
  input logic [DW-1:0] b_q,
  input logic [AW-1:0] c_addr,
  input logic          c_ce,
  input logic          c_we,
  input logic [DW-1:0] c_d
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !a_ce && !b_ce && !c_we && !ready);
  // R3
  write_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_we |-> c_ce);
  // R4
  read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_ce |-> b_ce && a_addr[LG-1:0] == b_addr[AW-1:LG]);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !idle && !done |=> !idle);
  // R7
  ready_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> a_ce && !idle);
endmodule

bind mm_engine mm_engine_chk #(.N(N), .DW(DW)) u_chk (.*);

// File: tb/test_mm_engine.sv
module test_mm_engine;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic        done, idle, ready, a_ce, b_ce, c_ce, c_we;
  logic [7:0]  a_addr, b_addr, c_addr;
  logic [31:0] a_q, b_q, c_d;
  logic [31:0] am [256], bm [256], cm [256];
  int          tests = 0, fails = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  mm_engine i_mm_engine (.*);

  always @(posedge clk) begin
    if (a_ce) a_q <= am[a_addr];
    if (b_ce) b_q <= bm[b_addr];
    if (c_ce && c_we) cm[c_addr] <= c_d;
  end

  function automatic logic [31:0] dot(int r, int c);
    logic [31:0] s = '0;
    for (int k = 0; k < 16; k++) s = s + am[r*16+k] * bm[k*16+c];
    return s;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(int inj);
    int e_iss = 0, e_rdy = 0, e_idl = 0, e_dn = 0, e_wr = 0, wcnt = 0, e_mem = 0;
    logic [31:0] exp_c [256];
    for (int a = 0; a < 256; a++) begin
      cm[a] = 32'hDEADBEEF;
      exp_c[a] = dot(a / 16, a % 16);
    end
    @(negedge clk);
    start = 1'b1;
    for (int t = 1; t <= 4110; t++) begin
      @(negedge clk);
      start = (t == inj);
      begin
        int n = t - 1;
        bit ece = (t <= 4096);
        if (a_ce !== ece || b_ce !== ece) e_iss++;
        else if (ece && (a_addr !== 8'((n/256)*16 + n%16) || b_addr !== 8'((n%16)*16 + (n/16)%16))) e_iss++;
      end
      if (ready !== (t == 4096)) e_rdy++;
      if (idle !== (t >= 4100)) e_idl++;
      if (done !== (t == 4099)) e_dn++;
      begin
        bit ew = (t >= 18 && t <= 4098 && (t - 18) % 16 == 0);
        int p = (t - 18) / 16;
        if (c_we !== ew || c_ce !== ew) e_wr++;
        else if (ew && (c_addr !== 8'(p) || c_d !== exp_c[p])) e_wr++;
        if (c_we === 1'b1) wcnt++;
      end
    end
    for (int a = 0; a < 256; a++) if (cm[a] !== exp_c[a]) e_mem++;
    check(e_iss == 0, "R4 read issue", e_iss, 0);
    check(e_rdy == 0 && e_idl == 0, "R7 ready/idle", e_rdy + e_idl, 0);
    check(e_dn == 0, "R5 done timing", e_dn, 0);
    check(e_wr == 0, "R3 write order/data", e_wr, 0);
    check(wcnt == 256, "R3 write count", wcnt, 256);
    check(e_mem == 0, "R2 R8 R9 result memory", e_mem, 0);
  endtask

  initial begin
    void'($urandom(32'd20131116));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(idle === 1'b1, "R1 idle", idle, 1);
    check(!done && !ready && !a_ce && !b_ce && !c_ce && !c_we, "R1 quiet",
          {done, ready, a_ce, b_ce, c_ce, c_we}, 0);
    // R2 random full-range operands (R8 wraps naturally)
    for (int a = 0; a < 256; a++) begin am[a] = $urandom; bm[a] = $urandom; end
    run(0);
    // R9 back-to-back with new data, R6 start pulse mid-run
    for (int a = 0; a < 256; a++) begin am[a] = $urandom % 1000; bm[a] = $urandom % 1000 - 500; end
    run(700);
    // R6 start pulse coinciding with done
    for (int a = 0; a < 256; a++) begin am[a] = $urandom; bm[a] = $urandom; end
    run(4099);
    // R8 directed: each product is 2^32, and small negative sums
    for (int a = 0; a < 256; a++) begin
      am[a] = (a % 32 < 16) ? 32'h4000_0000 : 32'd1;
      bm[a] = (a % 2 == 0) ? 32'd4 : 32'hFFFF_FFFF;
    end
    run(0);
    check(cm[0] === 32'd0, "R8 wrap to zero", cm[0], 0);
    check(cm[17] === 32'hFFFF_FFF0, "R8 negative sum", cm[17], 32'hFFFF_FFF0);
    @(negedge clk);
    check(idle === 1'b1 && !a_ce, "R1 idle after runs", idle, 1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule